// File: doc/BRIEF.md
# Triple-Lane Fault Recovery Controller

This block sits behind a three-way majority voter in a triple-redundant processing system. On each rising edge of the voter clock where a vote result is presented, it reads one disagreement flag per lane and a flag that says no two lanes agreed. While all lanes agree it lets the voted word through. When exactly one lane disagrees it counts the fault against that lane. It then asks the two agreeing lanes to save and report their state images and waits for the result of comparing those two images.

If the images match, the faulty lane is told to realign from the saved image and its input queue is flushed. All lanes are released together once the two good lanes' queues have drained, and every fault count returns to zero. An image mismatch, a vote with no majority, or a faulty lane that keeps disagreeing until its count reaches the escalation limit ends in a one-cycle system reset pulse. The pulse clears every count and returns the controller to normal running.

Top module: `rcv_ctrl`

## Requirements
- R1: After reset, `pass_vote` is 1, `report_req`, `realign_req`, `flush_req` and `sys_reset` are 0, and every lane count in `err_count` is 0.
- R2: In normal running, a vote (`vote_stb`=1) with `lane_err`=0 and `no_major`=0 keeps `pass_vote` at 1 and leaves all counts unchanged.
- R3: In normal running, a vote with exactly one bit set in `lane_err` (bit i = lane i) sets lane i's count (field `err_count[2*i+1:2*i]` at the default width) to its old value plus one. From the next cycle on, `report_req` has the two other lanes' bits set and `pass_vote` is 0.
- R4: While reports are pending, `cmp_done`=1 with `cmp_equal`=1 ends the reports. From the next cycle on, `realign_req` and `flush_req` both carry only the faulty lane's bit.
- R5: While reports are pending, `cmp_done`=1 with `cmp_equal`=0 produces a `sys_reset` pulse in the next cycle.
- R6: In normal running, a vote with `no_major`=1, or with two or more bits of `lane_err` set, produces a `sys_reset` pulse in the next cycle.
- R7: During realignment the lanes are released only when the `lane_empty` bits of both good lanes are 1; the faulty lane's bit plays no part. On release `pass_vote` returns to 1 and all counts to 0 in the next cycle.
- R8: During recovery, flags on the good lanes and `no_major` are ignored: requests and counts stay as they were.
- R9: During recovery, a further error flag on the faulty lane increments its count. When that count would reach ESC_LIMIT (default 3), a `sys_reset` pulse follows instead of continuing the realignment.
- R10: `sys_reset` is high for exactly one cycle. During that cycle all counts read 0, and in the cycle after it the controller is back in normal running.
- R11: Flags presented while `vote_stb`=0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Voter clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| vote_stb | input | 1 | A vote result is present this cycle |
| lane_err | input | 3 | Per-lane disagreement flags, bit i = lane i |
| no_major | input | 1 | Voter found no two lanes agreeing |
| cmp_done | input | 1 | Image comparison result is valid |
| cmp_equal | input | 1 | The two reported images were equal |
| lane_empty | input | 3 | Per-lane input queue empty |
| pass_vote | output | 1 | Voted word may be forwarded |
| report_req | output | 3 | Ask lanes to save and report their image |
| realign_req | output | 3 | Ask the faulty lane to reload from the image |
| flush_req | output | 3 | Flush the faulty lane's input queue |
| sys_reset | output | 1 | One-cycle reset of all lanes |
| err_count | output | 3*CNT_W | Packed per-lane fault counts, lane i at bits [CNT_W*i +: CNT_W] |

## Verification
Every result of this controller is registered once. A decision taken on a rising edge becomes visible in the requests, the counts and the reset pulse right after that edge, and lasts until the edge that ends it. The bench changes inputs on the falling edge and reads outputs 2 ns after the following rising edge, so each check observes exactly one decision. The pulse-length and back-to-normal checks then read one more edge later. Ignored-stimulus cases are confirmed by reading the requests and counts in that same sampled cycle, before any further stimulus.

// File: rtl/rcv_pkg.sv
package rcv_pkg;

  localparam int unsigned LANES = 3;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_REPORT  = 2'd1,
    ST_REALIGN = 2'd2,
    ST_RESET   = 2'd3
  } rcv_state_e;

  // number of raised flags among the three lanes
  function automatic logic [1:0] flag_count(input logic [2:0] f);
    return {1'b0, f[0]} + {1'b0, f[1]} + {1'b0, f[2]};
  endfunction

  // index of the single raised flag (valid when flag_count == 1)
  function automatic logic [1:0] lane_index(input logic [2:0] f);
    if (f[2]) return 2'd2;
    if (f[1]) return 2'd1;
    return 2'd0;
  endfunction

  function automatic logic [2:0] lane_mask(input logic [1:0] idx);
    return 3'b001 << idx;
  endfunction

  // the two lanes that are not idx
  function automatic logic [2:0] peer_mask(input logic [1:0] idx);
    return ~lane_mask(idx);
  endfunction

endpackage

// File: rtl/rcv_vote_classify.sv
module rcv_vote_classify
  import rcv_pkg::*;
(
  input  logic       vote_stb,
  input  logic [2:0] lane_err,
  input  logic       no_major,
  output logic       cls_single,
  output logic       cls_multi,
  output logic [1:0] cls_lane
);

  logic [1:0] n_flags;

  always_comb begin
    n_flags    = flag_count(lane_err);
    cls_multi  = vote_stb && (no_major || (n_flags >= 2'd2));
    cls_single = vote_stb && !no_major && (n_flags == 2'd1);
    cls_lane   = lane_index(lane_err);
  end

endmodule

// File: rtl/rcv_err_counters.sv
module rcv_err_counters
  import rcv_pkg::*;
#(
  parameter int unsigned CNT_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LANES-1:0]       inc,
  input  logic                   clr,
  output logic [LANES*CNT_W-1:0] cnt_flat
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else if (clr) begin
        cnt_q <= '0;
      end else if (inc[g] && (cnt_q != CNT_MAX)) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end

    assign cnt_flat[g*CNT_W +: CNT_W] = cnt_q;
  end

endmodule

// File: rtl/rcv_recovery_fsm.sv
module rcv_recovery_fsm
  import rcv_pkg::*;
#(
  parameter int unsigned CNT_W     = 2,
  parameter int unsigned ESC_LIMIT = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   vote_stb,
  input  logic [2:0]             lane_err,
  input  logic                   cls_single,
  input  logic                   cls_multi,
  input  logic [1:0]             cls_lane,
  input  logic                   cmp_done,
  input  logic                   cmp_equal,
  input  logic [2:0]             lane_empty,
  input  logic [LANES*CNT_W-1:0] cnt_flat,
  output rcv_state_e             state,
  output logic [1:0]             bad_lane,
  output logic [LANES-1:0]       cnt_inc,
  output logic                   cnt_clr,
  output logic                   ev_release,
  output logic                   ev_escalate,
  output logic                   ev_mismatch
);

  localparam int unsigned XW = CNT_W + 1;
  localparam logic [XW-1:0] LIMIT_X = XW'(ESC_LIMIT);

  rcv_state_e state_q, state_d;
  logic [1:0] bad_q, bad_d;
  logic [1:0] sel_lane;
  logic [CNT_W-1:0] sel_cnt;
  logic [XW-1:0] sel_next;
  logic       recovering;
  logic       bad_flag;
  logic       hits_limit;

  always_comb begin
    recovering = (state_q == ST_REPORT) || (state_q == ST_REALIGN);
    sel_lane   = recovering ? bad_q : cls_lane;
    sel_cnt    = cnt_flat[sel_lane*CNT_W +: CNT_W];
    sel_next   = {1'b0, sel_cnt} + XW'(1);
    hits_limit = (sel_next >= LIMIT_X);
    bad_flag   = vote_stb && lane_err[bad_q];

    ev_escalate = recovering && bad_flag && hits_limit;
    ev_mismatch = (state_q == ST_REPORT) && !ev_escalate && cmp_done && !cmp_equal;
    ev_release  = (state_q == ST_REALIGN) && !ev_escalate &&
                  ((lane_empty & peer_mask(bad_q)) == peer_mask(bad_q));
  end

  always_comb begin
    state_d = state_q;
    bad_d   = bad_q;
    cnt_inc = '0;
    cnt_clr = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (cls_multi) begin
          state_d = ST_RESET;
          cnt_clr = 1'b1;
        end else if (cls_single) begin
          if (hits_limit) begin
            state_d = ST_RESET;
            cnt_clr = 1'b1;
          end else begin
            state_d = ST_REPORT;
            bad_d   = cls_lane;
            cnt_inc = lane_mask(cls_lane);
          end
        end
      end
      ST_REPORT: begin
        if (ev_escalate || ev_mismatch) begin
          state_d = ST_RESET;
          cnt_clr = 1'b1;
        end else begin
          if (bad_flag) cnt_inc = lane_mask(bad_q);
          if (cmp_done) state_d = ST_REALIGN;
        end
      end
      ST_REALIGN: begin
        if (ev_escalate) begin
          state_d = ST_RESET;
          cnt_clr = 1'b1;
        end else if (ev_release) begin
          state_d = ST_RUN;
          cnt_clr = 1'b1;
        end else if (bad_flag) begin
          cnt_inc = lane_mask(bad_q);
        end
      end
      ST_RESET: begin
        state_d = ST_RUN;
        cnt_clr = 1'b1;
      end
      default: begin
        state_d = ST_RUN;
        cnt_clr = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      bad_q   <= 2'd0;
    end else begin
      state_q <= state_d;
      bad_q   <= bad_d;
    end
  end

  assign state    = state_q;
  assign bad_lane = bad_q;

endmodule

// File: rtl/rcv_ctrl.sv
module rcv_ctrl
  import rcv_pkg::*;
#(
  parameter int unsigned CNT_W     = 2,
  parameter int unsigned ESC_LIMIT = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   vote_stb,
  input  logic [2:0]             lane_err,
  input  logic                   no_major,
  input  logic                   cmp_done,
  input  logic                   cmp_equal,
  input  logic [2:0]             lane_empty,
  output logic                   pass_vote,
  output logic [2:0]             report_req,
  output logic [2:0]             realign_req,
  output logic [2:0]             flush_req,
  output logic                   sys_reset,
  output logic [3*CNT_W-1:0]     err_count
);

  logic             cls_single;
  logic             cls_multi;
  logic [1:0]       cls_lane;
  logic [LANES-1:0] cnt_inc;
  logic             cnt_clr;
  logic             ev_release;
  logic             ev_escalate;
  logic             ev_mismatch;
  rcv_state_e       state;
  logic [1:0]       bad_lane;

  rcv_vote_classify u_classify (
    .vote_stb   (vote_stb),
    .lane_err   (lane_err),
    .no_major   (no_major),
    .cls_single (cls_single),
    .cls_multi  (cls_multi),
    .cls_lane   (cls_lane)
  );

  rcv_err_counters #(.CNT_W(CNT_W)) u_counters (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (cnt_inc),
    .clr      (cnt_clr),
    .cnt_flat (err_count)
  );

  rcv_recovery_fsm #(.CNT_W(CNT_W), .ESC_LIMIT(ESC_LIMIT)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .vote_stb    (vote_stb),
    .lane_err    (lane_err),
    .cls_single  (cls_single),
    .cls_multi   (cls_multi),
    .cls_lane    (cls_lane),
    .cmp_done    (cmp_done),
    .cmp_equal   (cmp_equal),
    .lane_empty  (lane_empty),
    .cnt_flat    (err_count),
    .state       (state),
    .bad_lane    (bad_lane),
    .cnt_inc     (cnt_inc),
    .cnt_clr     (cnt_clr),
    .ev_release  (ev_release),
    .ev_escalate (ev_escalate),
    .ev_mismatch (ev_mismatch)
  );

  always_comb begin
    pass_vote   = (state == ST_RUN);
    sys_reset   = (state == ST_RESET);
    report_req  = (state == ST_REPORT)  ? peer_mask(bad_lane) : 3'b000;
    realign_req = (state == ST_REALIGN) ? lane_mask(bad_lane) : 3'b000;
    flush_req   = realign_req;
  end

endmodule

// File: rtl/rcv_ctrl_chk.sv
module rcv_ctrl_chk #(
  parameter int unsigned CNT_W     = 2,
  parameter int unsigned ESC_LIMIT = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               vote_stb,
  input logic [2:0]         lane_err,
  input logic               no_major,
  input logic               cmp_done,
  input logic               cmp_equal,
  input logic [2:0]         lane_empty,
  input logic               pass_vote,
  input logic [2:0]         report_req,
  input logic [2:0]         realign_req,
  input logic [2:0]         flush_req,
  input logic               sys_reset,
  input logic [3*CNT_W-1:0] err_count,
  input logic               ev_release,
  input logic               ev_escalate,
  input logic               ev_mismatch
);

  // R2: a clean vote keeps the pass path and the counts
  assert_clean_vote_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_vote && vote_stb && !no_major && lane_err == 3'b000)
      |=> (pass_vote && $stable(err_count)));

  // R3: reports always go to exactly two lanes, never with a realign
  assert_report_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (report_req != 3'b000)
      |-> ($countones(report_req) == 2 && realign_req == 3'b000 && !pass_vote));

  // R4: realign targets one lane and its queue flush goes with it
  assert_realign_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (realign_req != 3'b000)
      |-> ($onehot0(realign_req) && flush_req == realign_req && report_req == 3'b000));

  // R5: image mismatch leads to the reset pulse
  assert_mismatch_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mismatch |=> sys_reset);

  // R6: no majority in normal running leads to the reset pulse
  assert_no_majority_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_vote && vote_stb && (no_major || $countones(lane_err) >= 2))
      |=> sys_reset);

  // R7: release waits for both good queues and clears the counts
  assert_release_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (realign_req != 3'b000 && (lane_empty | realign_req) != 3'b111)
      |=> !pass_vote);
  assert_release_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_release |=> (pass_vote && err_count == '0));

  // R9: escalation ends in the reset pulse
  assert_escalate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_escalate |=> sys_reset);
  assert_below_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(err_count[CNT_W-1:0]) < ESC_LIMIT) &&
    (int'(err_count[2*CNT_W-1:CNT_W]) < ESC_LIMIT) &&
    (int'(err_count[3*CNT_W-1:2*CNT_W]) < ESC_LIMIT));

  // R10: reset pulse is one cycle, counts zero, back to running
  assert_pulse_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset |=> (!sys_reset && pass_vote));
  assert_pulse_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset |-> (err_count == '0 && report_req == 3'b000 && realign_req == 3'b000));

  // R11: without a strobe nothing moves in normal running
  assert_no_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_vote && !vote_stb) |=> (pass_vote && $stable(err_count)));

  // R5 companion: equal compare never resets by itself
  assert_equal_no_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (report_req != 3'b000 && cmp_done && cmp_equal && !ev_escalate) |=> (realign_req != 3'b000));

endmodule

bind rcv_ctrl rcv_ctrl_chk #(.CNT_W(CNT_W), .ESC_LIMIT(ESC_LIMIT)) u_rcv_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .vote_stb    (vote_stb),
  .lane_err    (lane_err),
  .no_major    (no_major),
  .cmp_done    (cmp_done),
  .cmp_equal   (cmp_equal),
  .lane_empty  (lane_empty),
  .pass_vote   (pass_vote),
  .report_req  (report_req),
  .realign_req (realign_req),
  .flush_req   (flush_req),
  .sys_reset   (sys_reset),
  .err_count   (err_count),
  .ev_release  (ev_release),
  .ev_escalate (ev_escalate),
  .ev_mismatch (ev_mismatch)
);

// File: tb/tb_rcv_ctrl.sv
`timescale 1ns/1ps
module tb_rcv_ctrl;

  localparam int CW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          vote_stb = 1'b0;
  logic [2:0]    lane_err = 3'b000;
  logic          no_major = 1'b0;
  logic          cmp_done = 1'b0;
  logic          cmp_equal = 1'b0;
  logic [2:0]    lane_empty = 3'b000;
  logic          pass_vote;
  logic [2:0]    report_req;
  logic [2:0]    realign_req;
  logic [2:0]    flush_req;
  logic          sys_reset;
  logic [3*CW-1:0] err_count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rcv_ctrl #(.CNT_W(CW), .ESC_LIMIT(3)) dut (
    .clk(clk), .rst_n(rst_n), .vote_stb(vote_stb), .lane_err(lane_err),
    .no_major(no_major), .cmp_done(cmp_done), .cmp_equal(cmp_equal),
    .lane_empty(lane_empty), .pass_vote(pass_vote), .report_req(report_req),
    .realign_req(realign_req), .flush_req(flush_req), .sys_reset(sys_reset),
    .err_count(err_count)
  );

  function automatic int cnt_of(input int lane);
    return int'(err_count[lane*CW +: CW]);
  endfunction

  function automatic logic [2:0] one(input int lane);
    return 3'b001 << lane;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // inputs change on the falling edge, outputs are read 2 ns after the rising edge
  task automatic edge_and_sample();
    @(posedge clk);
    #2;
  endtask

  task automatic present(input logic stb, input logic [2:0] e, input logic nm,
                         input logic cd, input logic ce);
    @(negedge clk);
    vote_stb = stb; lane_err = e; no_major = nm; cmp_done = cd; cmp_equal = ce;
    edge_and_sample();
    vote_stb = 1'b0; lane_err = 3'b000; no_major = 1'b0; cmp_done = 1'b0; cmp_equal = 1'b0;
  endtask

  task automatic expect_running(input string req);
    chk({req, " pass_vote"}, int'(pass_vote), 1);
    chk({req, " report_req"}, int'(report_req), 0);
    chk({req, " realign_req"}, int'(realign_req), 0);
    chk({req, " sys_reset"}, int'(sys_reset), 0);
    for (int l = 0; l < 3; l++) chk({req, " count"}, cnt_of(l), 0);
  endtask

  task automatic t_reset_state();
    expect_running("R1");
    chk("R1 flush_req", int'(flush_req), 0);
  endtask

  task automatic t_clean_and_nostrobe();
    present(1'b1, 3'b000, 1'b0, 1'b0, 1'b0);
    expect_running("R2");
    present(1'b0, 3'b010, 1'b0, 1'b0, 1'b0);   // R11: no strobe
    expect_running("R11");
    present(1'b0, 3'b111, 1'b1, 1'b0, 1'b0);
    expect_running("R11 no_major");
  endtask

  task automatic t_full_recovery(input int lane);
    logic [2:0] peers = ~one(lane);
    present(1'b1, one(lane), 1'b0, 1'b0, 1'b0);
    chk("R3 report_req", int'(report_req), int'(peers));
    chk("R3 count", cnt_of(lane), 1);
    chk("R3 pass_vote", int'(pass_vote), 0);
    // R8: good-lane flags and no_major ignored
    present(1'b1, peers, 1'b1, 1'b0, 1'b0);
    chk("R8 report_req", int'(report_req), int'(peers));
    chk("R8 sys_reset", int'(sys_reset), 0);
    for (int l = 0; l < 3; l++) chk("R8 count", cnt_of(l), (l == lane) ? 1 : 0);
    present(1'b0, 3'b000, 1'b0, 1'b1, 1'b1);
    chk("R4 report_req", int'(report_req), 0);
    chk("R4 realign_req", int'(realign_req), int'(one(lane)));
    chk("R4 flush_req", int'(flush_req), int'(one(lane)));
    // R7: only one good queue empty plus the faulty one: no release
    @(negedge clk);
    lane_empty = one(lane) | one((lane + 1) % 3);
    edge_and_sample();
    chk("R7 hold realign", int'(realign_req), int'(one(lane)));
    chk("R7 hold pass", int'(pass_vote), 0);
    // R8 again during realignment
    present(1'b1, one((lane + 2) % 3), 1'b1, 1'b0, 1'b0);
    chk("R8 realign kept", int'(realign_req), int'(one(lane)));
    @(negedge clk);
    lane_empty = peers;
    edge_and_sample();
    lane_empty = 3'b000;
    expect_running("R7 release");
  endtask

  task automatic t_mismatch();
    present(1'b1, 3'b010, 1'b0, 1'b0, 1'b0);
    chk("R3 count lane1", cnt_of(1), 1);
    present(1'b0, 3'b000, 1'b0, 1'b1, 1'b0);
    chk("R5 sys_reset", int'(sys_reset), 1);
    chk("R10 count cleared", cnt_of(1), 0);
    chk("R5 no realign", int'(realign_req), 0);
    edge_and_sample();
    expect_running("R10 after pulse");
  endtask

  task automatic t_no_majority();
    present(1'b1, 3'b000, 1'b1, 1'b0, 1'b0);
    chk("R6 no_major pulse", int'(sys_reset), 1);
    edge_and_sample();
    chk("R10 one cycle", int'(sys_reset), 0);
    present(1'b1, 3'b101, 1'b0, 1'b0, 1'b0);
    chk("R6 two flags pulse", int'(sys_reset), 1);
    chk("R6 counts", int'(err_count), 0);
    edge_and_sample();
    expect_running("R10 back");
  endtask

  task automatic t_escalate();
    present(1'b1, 3'b100, 1'b0, 1'b0, 1'b0);
    chk("R9 first count", cnt_of(2), 1);
    present(1'b1, 3'b100, 1'b0, 1'b0, 1'b0);
    chk("R9 second count", cnt_of(2), 2);
    chk("R9 still reporting", int'(report_req), 3'b011);
    present(1'b0, 3'b000, 1'b0, 1'b1, 1'b1);
    chk("R9 realign", int'(realign_req), 3'b100);
    present(1'b1, 3'b100, 1'b0, 1'b0, 1'b0);
    chk("R9 escalated pulse", int'(sys_reset), 1);
    chk("R9 realign dropped", int'(realign_req), 0);
    chk("R10 counts zero", int'(err_count), 0);
    edge_and_sample();
    expect_running("R10 after escalation");
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    edge_and_sample();
    t_reset_state();
    t_clean_and_nostrobe();
    for (int l = 0; l < 3; l++) t_full_recovery(l);
    t_mismatch();
    t_no_majority();
    t_escalate();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule